// File: doc/BRIEF.md
# Banked Shared Memory with Pipelined Client Crossbar

This block is a shared data memory for a cluster of load/store clients. The storage is split into a power-of-two number of single-port banks. Every client may present one access per cycle. The word address selects the bank, so accesses that land in different banks all go ahead together. When several clients aim at the same bank in one cycle, that bank's round-robin arbiter grants one of them. The others see their stall asserted in that same cycle and must keep their request unchanged until a later grant.

The client count and the bank count are separate parameters. Fewer banks than clients saves area but raises the conflict rate. A grant is given combinationally in the request cycle. Writes take effect at the end of that cycle, with per-byte enables. Read data travels back through a return pipeline and reaches the issuing client exactly `LAT` cycles after its grant. `LAT` is a parameter limited to 2 or 3. Each client receives its read results in the order it issued them.

Top module: `mbank_xbar`

## Requirements
- R1: The bank index is taken from the word address directly above the byte offset. With the default configuration of four 32-bit lanes and four banks, this is address bits [3:2], and the bank row is bits [9:4]. Address bits [1:0] never affect bank choice.
- R2: For a granted read in cycle k, `rvalid_o` of that client is high in cycle k+LAT. `rdata_o` then carries the word stored at the addressed location. `rvalid_o` is low in every cycle that does not follow a granted read by exactly LAT cycles.
- R3: A requesting client that is the only requester of its bank in a cycle is granted in that cycle, so clients on distinct banks all proceed in parallel.
- R4: At most one client is granted per bank per cycle, and `gnt_o` is never high for a client whose `req_i` is low.
- R5: Each bank picks its winner by rotating priority. After client w is granted at a bank, that bank searches from client w+1 (wrapping) on its next grant. A client that keeps requesting is therefore granted within N_CLI cycles.
- R6: `stall_o` of a client equals a request that was not granted in that cycle. A stalled client that holds its request is served later with a correct result.
- R7: On a granted write, only the bytes whose `be_i` bit is set are updated. Bit i covers data bits [8i+7:8i], and the other bytes keep their old value.
- R8: A read and a write to the same bank in the same cycle are serialized: exactly one is granted. A read that follows a write to the same address returns the written data.
- R9: After reset, no grant, stall or read-valid is asserted while no request is present, and every bank gives client 0 highest priority on its first grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_CLI | Per-client access request |
| we_i | input | N_CLI | Per-client write (1) or read (0) |
| addr_i | input | N_CLI*ADDR_W | Per-client byte address, client c in slice c |
| wdata_i | input | N_CLI*DATA_W | Per-client write data |
| be_i | input | N_CLI*DATA_W/8 | Per-client byte enables |
| gnt_o | output | N_CLI | Access accepted this cycle |
| stall_o | output | N_CLI | Request present but not accepted this cycle |
| rvalid_o | output | N_CLI | Read data valid |
| rdata_o | output | N_CLI*DATA_W | Per-client read data |

## Verification
In one cycle, a bank grant for a new access can coincide with the return of an earlier read to the same client, and a write to a bank can contend with a read of the same word. Long runs of mixed traffic with random addresses, directions and byte enables produce both overlaps. Held requests add back-to-back conflicts at a single bank. The bench keeps its own rotating-priority model per bank, a word-level image of the storage updated at each write grant, and a LAT-deep queue of expected returns per client. Each cycle it compares grants, stalls, read valids and read data against these models.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned LAT_MIN = 2;
  localparam int unsigned LAT_MAX = 3;
  localparam int unsigned MAX_CLI = 8;
  localparam int unsigned MAX_BANK = 8;

  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_e;
endpackage

// File: rtl/mbx_rr_arb.sv
module mbx_rr_arb #(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o
);
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] win;

  // search from ptr_q upwards; the lowest rotated offset wins
  always_comb begin
    gnt_o = '0;
    win   = '0;
    for (int k = int'(N_REQ) - 1; k >= 0; k--) begin
      if (req_i[(int'(ptr_q) + k) % int'(N_REQ)]) begin
        gnt_o = '0;
        gnt_o[(int'(ptr_q) + k) % int'(N_REQ)] = 1'b1;
        win = IDX_W'((int'(ptr_q) + k) % int'(N_REQ));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (|gnt_o) begin
      ptr_q <= (win == IDX_W'(N_REQ - 1)) ? '0 : win + 1'b1;
    end
  end

  a_r4_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r4_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  // R5: bounded wait per requester, tracked with a counter
  for (genvar r = 0; r < N_REQ; r++) begin : g_wait
    logic [IDX_W:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wait_q <= '0;
      end else if (req_i[r] && !gnt_o[r]) begin
        wait_q <= wait_q + 1'b1;
      end else begin
        wait_q <= '0;
      end
    end
    a_r5_bounded_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(wait_q) < int'(N_REQ));
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROWS   = 64,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];
  logic [DATA_W-1:0] rdata_q;

  for (genvar k = 0; k < BE_W; k++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (en_i && we_i && be_i[k]) begin
        mem_q[row_i][8*k +: 8] <= wdata_i[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && !we_i) begin
      rdata_q <= mem_q[row_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbx_ret_pipe.sv
module mbx_ret_pipe #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_BANK = 4,
  parameter int unsigned LAT    = 2,
  localparam int unsigned BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int unsigned NS     = LAT - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     issue_i,
  input  logic [BANK_W-1:0]        bsel_i,
  input  logic [N_BANK*DATA_W-1:0] bank_rdata_i,
  output logic                     rvalid_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic              v0_q;
  logic [BANK_W-1:0] b0_q;
  logic [DATA_W-1:0] pick;
  logic              v_q [NS];
  logic [DATA_W-1:0] d_q [NS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0_q <= 1'b0;
      b0_q <= '0;
    end else begin
      v0_q <= issue_i;
      b0_q <= bsel_i;
    end
  end

  // bank output registers are shared; pick this client's bank one cycle after issue
  assign pick = bank_rdata_i[int'(b0_q)*DATA_W +: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NS); i++) begin
        v_q[i] <= 1'b0;
        d_q[i] <= '0;
      end
    end else begin
      v_q[0] <= v0_q;
      d_q[0] <= v0_q ? pick : '0;
      for (int i = 1; i < int'(NS); i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign rvalid_o = v_q[NS-1];
  assign rdata_o  = d_q[NS-1];

  a_r2_return_after_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> ##LAT rvalid_o);

  a_r2_no_spurious_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |-> ##LAT !rvalid_o);
endmodule

// File: rtl/mbank_xbar.sv
module mbank_xbar
  import mbx_pkg::*;
#(
  parameter int unsigned N_CLI  = 4,
  parameter int unsigned N_BANK = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ROWS   = 64,
  parameter int unsigned LAT    = 2,
  localparam int unsigned BE_W      = DATA_W / 8,
  localparam int unsigned BYTE_OFF  = (BE_W > 1) ? $clog2(BE_W) : 0,
  localparam int unsigned BANK_BITS = (N_BANK > 1) ? $clog2(N_BANK) : 0,
  localparam int unsigned BANK_W    = (N_BANK > 1) ? BANK_BITS : 1,
  localparam int unsigned ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CLI-1:0]        req_i,
  input  logic [N_CLI-1:0]        we_i,
  input  logic [N_CLI*ADDR_W-1:0] addr_i,
  input  logic [N_CLI*DATA_W-1:0] wdata_i,
  input  logic [N_CLI*BE_W-1:0]   be_i,
  output logic [N_CLI-1:0]        gnt_o,
  output logic [N_CLI-1:0]        stall_o,
  output logic [N_CLI-1:0]        rvalid_o,
  output logic [N_CLI*DATA_W-1:0] rdata_o
);
  logic [BANK_W-1:0] bank_sel [N_CLI];
  logic [ROW_W-1:0]  row      [N_CLI];
  logic [N_CLI-1:0]  breq     [N_BANK];
  logic [N_CLI-1:0]  bgnt     [N_BANK];

  logic              b_en    [N_BANK];
  logic              b_we    [N_BANK];
  logic [ROW_W-1:0]  b_row   [N_BANK];
  logic [DATA_W-1:0] b_wdata [N_BANK];
  logic [BE_W-1:0]   b_be    [N_BANK];
  logic [N_BANK*DATA_W-1:0] bank_rd_flat;

  // address decode
  for (genvar c = 0; c < N_CLI; c++) begin : g_dec
    if (N_BANK > 1) begin : g_multi
      assign bank_sel[c] = addr_i[c*ADDR_W + BYTE_OFF +: BANK_W];
    end else begin : g_single
      assign bank_sel[c] = '0;
    end
    assign row[c] = addr_i[c*ADDR_W + BYTE_OFF + BANK_BITS +: ROW_W];
  end

  // per-bank request vectors and arbiters
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    for (genvar c = 0; c < N_CLI; c++) begin : g_req
      assign breq[b][c] = req_i[c] && (bank_sel[c] == BANK_W'(b));
    end

    mbx_rr_arb #(.N_REQ(N_CLI)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (breq[b]),
      .gnt_o  (bgnt[b])
    );

    // grant vector is one-hot, so an OR-mux suffices
    always_comb begin
      b_we[b]    = 1'b0;
      b_row[b]   = '0;
      b_wdata[b] = '0;
      b_be[b]    = '0;
      for (int c = 0; c < int'(N_CLI); c++) begin
        if (bgnt[b][c]) begin
          b_we[b]    = b_we[b] | (acc_e'(we_i[c]) == ACC_WR);
          b_row[b]   = b_row[b] | row[c];
          b_wdata[b] = b_wdata[b] | wdata_i[c*DATA_W +: DATA_W];
          b_be[b]    = b_be[b] | be_i[c*BE_W +: BE_W];
        end
      end
    end
    assign b_en[b] = |bgnt[b];

    mbx_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank (
      .clk_i   (clk_i),
      .en_i    (b_en[b]),
      .we_i    (b_we[b]),
      .row_i   (b_row[b]),
      .wdata_i (b_wdata[b]),
      .be_i    (b_be[b]),
      .rdata_o (bank_rd_flat[b*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    gnt_o = '0;
    for (int b = 0; b < int'(N_BANK); b++) begin
      gnt_o = gnt_o | bgnt[b];
    end
  end

  assign stall_o = req_i & ~gnt_o;

  // per-client return path
  for (genvar c = 0; c < N_CLI; c++) begin : g_ret
    mbx_ret_pipe #(.DATA_W(DATA_W), .N_BANK(N_BANK), .LAT(LAT)) u_ret (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .issue_i      (gnt_o[c] && !we_i[c]),
      .bsel_i       (bank_sel[c]),
      .bank_rdata_i (bank_rd_flat),
      .rvalid_o     (rvalid_o[c]),
      .rdata_o      (rdata_o[c*DATA_W +: DATA_W])
    );

    a_r3_sole_requester_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[c] && ($countones(breq[bank_sel[c]]) == 1)) |-> gnt_o[c]);

    a_r6_stalled_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o[c] |=> (req_i[c] && $stable(we_i[c]) &&
                      $stable(addr_i[c*ADDR_W +: ADDR_W])));
  end
endmodule

// File: tb/tb_mbank_xbar.sv
module tb_mbank_xbar;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NC = 4;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int RW = 64;
  localparam int LAT = 2;
  localparam int BEW = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    req = '0, we = '0;
  logic [NC*AW-1:0] addr = '0;
  logic [NC*DW-1:0] wdata = '0;
  logic [NC*BEW-1:0] be = '0;
  logic [NC-1:0]    gnt, stall, rvalid;
  logic [NC*DW-1:0] rdata;

  always #5 clk = ~clk;

  mbank_xbar #(.N_CLI(NC), .N_BANK(NB), .DATA_W(DW), .ADDR_W(AW), .ROWS(RW), .LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .gnt_o(gnt), .stall_o(stall),
    .rvalid_o(rvalid), .rdata_o(rdata)
  );

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  bit          op_v  [NC];
  bit          op_we [NC];
  logic [15:0] op_a  [NC];
  logic [31:0] op_d  [NC];
  logic [3:0]  op_be [NC];

  logic [31:0] mem_m [NB*RW];
  int          ptr_m [NB];
  bit          ev [NC][LAT+1];
  logic [31:0] ed [NC][LAT+1];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // R1: bank = word address bits [3:2], word index = bits [9:2]
  function automatic int bank_of(logic [15:0] a);
    return int'(a[3:2]);
  endfunction

  task automatic chk(input bit ok, input string msg);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic set_op(int c, bit w, logic [15:0] a, logic [31:0] d, logic [3:0] b);
    op_v[c] = 1; op_we[c] = w; op_a[c] = a; op_d[c] = d; op_be[c] = b;
  endtask

  task automatic do_cycle();
    bit eg [NC];
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      req[c] = op_v[c];
      we[c]  = op_we[c];
      addr[c*AW +: AW]   = op_a[c];
      wdata[c*DW +: DW]  = op_d[c];
      be[c*BEW +: BEW]   = op_be[c];
    end
    #4;
    for (int c = 0; c < NC; c++) eg[c] = 0;
    for (int b = 0; b < NB; b++) begin
      int win = -1;
      for (int i = 0; i < NC; i++) begin
        int c = (ptr_m[b] + i) % NC;
        if (win < 0 && op_v[c] && bank_of(op_a[c]) == b) win = c;
      end
      if (win >= 0) begin
        eg[win] = 1;
        ptr_m[b] = (win + 1) % NC;
      end
    end
    for (int c = 0; c < NC; c++) begin
      chk(gnt[c] == eg[c], $sformatf("R4 R5 gnt client %0d act %0b exp %0b", c, gnt[c], eg[c]));
      chk(stall[c] == (op_v[c] && !eg[c]),
          $sformatf("R6 stall client %0d act %0b exp %0b", c, stall[c], op_v[c] && !eg[c]));
      for (int i = LAT; i > 0; i--) begin
        ev[c][i] = ev[c][i-1];
        ed[c][i] = ed[c][i-1];
      end
      ev[c][0] = 0;
      ed[c][0] = '0;
    end
    for (int c = 0; c < NC; c++) begin
      if (eg[c]) begin
        int w = int'(op_a[c][9:2]);
        if (op_we[c]) begin
          for (int k = 0; k < BEW; k++)
            if (op_be[c][k]) mem_m[w][8*k +: 8] = op_d[c][8*k +: 8];
        end else begin
          ev[c][0] = 1;
          ed[c][0] = mem_m[w];
        end
      end
    end
    for (int c = 0; c < NC; c++) begin
      chk(rvalid[c] == ev[c][LAT],
          $sformatf("R2 rvalid client %0d act %0b exp %0b", c, rvalid[c], ev[c][LAT]));
      if (ev[c][LAT])
        chk(rdata[c*DW +: DW] === ed[c][LAT],
            $sformatf("R2 R6 R7 R8 rdata client %0d act %h exp %h", c, rdata[c*DW +: DW], ed[c][LAT]));
    end
    for (int c = 0; c < NC; c++) if (gnt[c]) op_v[c] = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) do_cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    nvec++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      op_v[c] = 0; op_we[c] = 0; op_a[c] = '0; op_d[c] = '0; op_be[c] = '0;
      for (int i = 0; i <= LAT; i++) begin ev[c][i] = 0; ed[c][i] = '0; end
    end
    for (int b = 0; b < NB; b++) ptr_m[b] = 0;
    for (int w = 0; w < NB*RW; w++) mem_m[w] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R9: quiet outputs after reset
    @(negedge clk); #4;
    chk(gnt == '0 && stall == '0 && rvalid == '0,
        $sformatf("R9 reset outputs act %b%b%b exp 0", gnt, stall, rvalid));

    // R9 R5: all clients write bank 0; order must be 0,1,2,3
    for (int c = 0; c < NC; c++) set_op(c, 1, 16'(c << 4), 32'hA000_0000 + c, 4'hF);
    for (int k = 0; k < NC; k++) begin
      do_cycle();
      chk(gnt == 4'(1 << k), $sformatf("R9 R5 rotation step %0d act %b exp %b", k, gnt, 4'(1 << k)));
    end

    // R3 R1: fill memory, each client on its own bank
    for (int r = 0; r < RW; r++) begin
      for (int c = 0; c < NC; c++)
        set_op(c, 1, 16'((r << 4) | (c << 2)), rnd(), 4'hF);
      do_cycle();
      chk(gnt == 4'hF, $sformatf("R3 distinct banks act %b exp 1111", gnt));
    end

    // R1: byte offset bits do not steer; 0x0006 and 0x0015 both hit bank 1
    set_op(0, 0, 16'h0006, '0, '0);
    set_op(1, 0, 16'h0015, '0, '0);
    do_cycle();
    chk($countones(gnt[1:0]) == 1 && $countones(stall[1:0]) == 1,
        $sformatf("R1 byte offset ignored act gnt %b stall %b", gnt[1:0], stall[1:0]));
    do_cycle();
    idle(LAT + 1);

    // R7: partial byte write then read back
    set_op(2, 1, 16'h0100, 32'h1122_3344, 4'b0101);
    do_cycle();
    set_op(2, 0, 16'h0100, '0, '0);
    idle(1 + LAT);

    // R8: write and read of one word in the same cycle
    set_op(2, 1, 16'h0040, 32'hDEAD_BEEF, 4'hF);
    set_op(3, 0, 16'h0040, '0, '0);
    do_cycle();
    chk($countones(gnt[3:2]) == 1, $sformatf("R8 serialized act %b exp one grant", gnt[3:2]));
    idle(2 + LAT);

    // R6: heavy conflict on one bank with held requests
    for (int n = 0; n < 40; n++) begin
      for (int c = 0; c < NC; c++)
        if (!op_v[c]) set_op(c, rnd() % 3 == 0, 16'({6'(rnd()), 2'b10, 2'b00}), rnd(), 4'(rnd()));
      do_cycle();
    end

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < NC; c++)
        if (!op_v[c] && (rnd() % 4 != 0))
          set_op(c, rnd() % 2 == 0, 16'({6'(rnd()), 2'(rnd()), 2'(rnd())}), rnd(), 4'(rnd()));
      do_cycle();
    end
    for (int n = 0; n < 20; n++) do_cycle();
    idle(LAT + 2);
    finish_run();
  end
endmodule